// File: doc/BRIEF.md
# Sharpness Controller Register Bank

This block is the register file behind a two-wire serial control port on a video sharpness processor. A byte-level bus front end, which is outside this block, reports start and stop conditions and hands over each received byte with a one-cycle strobe. The block answers each byte with an acknowledge decision or, during a read, with the byte to be shifted out. The block decodes its own device address, which one address-select pin sets to one of two values.

Five write locations hold the feature controls. Location 0 is a control nibble. Locations 1 to 4 hold four 6-bit feature levels: peaking, edge steepness, coring and line width. A write transfer names a start location, and each further data byte lands on the next location. A read transfer has no location of its own. It always begins with a status byte, then returns two 6-bit converter results, then pads with all-ones. The status byte carries a sticky supply-loss flag that only a status read clears, a fixed 3-bit identity code and a converter-data-valid bit.

A standby-release bit in the control nibble decides where the active feature values come from. When the bit is clear, which it is after reset, the active values follow the external pin-derived inputs. When the bit is set, they follow the register contents. The active outputs are registered, so any change appears one clock after the cause.

Top module: `sharp_ctl_bank`

## Requirements
- R1: The first byte after a start is the address byte. Its bits 7:1 are compared against {addr_sel, 1, addr_sel, 0000}, which gives 40h when addr_sel is 0 and E0h when it is 1 as an 8-bit write address. Bit 0 selects read (1) or write (0). rsp_ack is 1 only on a match.
- R2: Location 0 stores data bits 3:0 as standby-release (bit 0), range select (bit 1), line-rate select (bit 2) and filter select (bit 3), and drops bits 7:4. Locations 1, 2, 3 and 4 store data bits 5:0 as peaking, steepness, coring and line width.
- R3: In a write transfer, the byte after the address is the start location. Each data byte is written to the current location, and the location then advances by one, saturating at FFh.
- R4: A data byte aimed at a location above 4 is acknowledged and changes no register.
- R5: A read transfer returns the status byte first, then {00, adc_in1}, then {00, adc_in2}, then FFh for every further byte. Read bytes are never acknowledged by the block.
- R6: The status byte holds the supply-loss flag in bit 7, the identity code (default 101b) in bits 6:4, zeros in bits 3:1 and adc_dv in bit 0.
- R7: The supply-loss flag is 1 after reset and is set by a power_fail pulse. Only the return of the status byte clears it. A power_fail in the same cycle as that read keeps it set.
- R8: While standby-release is 0, every act_* feature output equals the matching pin input of the previous clock. While it is 1, they equal the register contents of the previous clock. act_stb shows the stored bit one clock late.
- R9: The response (rsp_valid, and rsp_ack where due) is registered and appears in the clock after the byte strobe. A transfer with a non-matching address produces no further response and no register change until the next start. A stop ends any transfer.
- R10: A start inside a transfer begins a new address phase, so a write can be followed directly by a read without a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| addr_sel | input | 1 | device address select |
| bus_start | input | 1 | start condition pulse |
| bus_stop | input | 1 | stop condition pulse |
| byte_stb | input | 1 | byte strobe: received byte or read request |
| byte_in | input | 8 | received byte |
| rsp_valid | output | 1 | response for the previous strobe |
| rsp_ack | output | 1 | acknowledge decision |
| rsp_data | output | 8 | byte to be sent on a read |
| power_fail | input | 1 | supply interruption pulse |
| adc_in1 | input | 6 | converter result, input 1 |
| adc_in2 | input | 6 | converter result, input 2 |
| adc_dv | input | 1 | converter data valid |
| pin_ams | input | 1 | pin-derived range select |
| pin_fhs | input | 1 | pin-derived line-rate select |
| pin_cfs | input | 1 | pin-derived filter select |
| pin_peak | input | 6 | pin-derived peaking |
| pin_steep | input | 6 | pin-derived steepness |
| pin_core | input | 6 | pin-derived coring |
| pin_width | input | 6 | pin-derived line width |
| act_stb | output | 1 | standby-release bit in force |
| act_ams | output | 1 | active range select |
| act_fhs | output | 1 | active line-rate select |
| act_cfs | output | 1 | active filter select |
| act_peak | output | 6 | active peaking |
| act_steep | output | 6 | active steepness |
| act_core | output | 6 | active coring |
| act_width | output | 6 | active line width |

## Verification
The bench sweeps every address byte for both settings of addr_sel. A wrong match constant or a dropped direction bit would acknowledge foreign devices or stay silent to its own. It steps a setting through all 64 values and writes across the end of the map. A decoder that wraps or masks the location would corrupt location 0 or another setting. On the read side it checks the fixed read order, the FFh padding and the sticky flag's survival of a write transfer and of a stray power_fail, because a flag cleared on any read or on any access would lose a supply drop. It also checks the one-clock lag of the standby hand-over and a read that follows a write through a repeated start.

// File: rtl/sharp_ctl_pkg.sv
package sharp_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_WR,
        PH_RD
    } phase_t;

    typedef struct packed {
        logic cfs;
        logic fhs;
        logic ams;
        logic stb;
    } ctrl_t;

    typedef struct packed {
        logic       en;
        logic [7:0] loc;
        logic [7:0] data;
    } wr_req_t;

    localparam int unsigned LOC_W    = 8;
    localparam int unsigned READ_LEN = 3;

    function automatic logic [6:0] dev_addr(input logic sel);
        return {sel, 1'b1, sel, 4'b0000};
    endfunction

    function automatic logic [7:0] inc_sat(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    function automatic logic [7:0] status_byte(input logic flag, input logic [2:0] id,
                                               input logic dv);
        return {flag, id, 3'b000, dv};
    endfunction

endpackage

// File: rtl/sharp_ctl_xfer.sv
module sharp_ctl_xfer
    import sharp_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_sel,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       byte_stb,
    input  logic [7:0] byte_in,
    output phase_t     phase,
    output wr_req_t    wr,
    output logic       rd_fire,
    output logic [7:0] rd_idx,
    output logic       rsp_valid,
    output logic       rsp_ack
);

    logic [7:0] wr_ptr;
    logic [7:0] rd_ptr;
    logic       take;
    logic       hit;

    // a byte strobe counts only when no bus condition arrives with it
    assign take = byte_stb && !bus_start && !bus_stop;
    assign hit  = (byte_in[7:1] == dev_addr(addr_sel));

    assign wr.en    = take && (phase == PH_WR);
    assign wr.loc   = wr_ptr;
    assign wr.data  = byte_in;
    assign rd_fire  = take && (phase == PH_RD);
    assign rd_idx   = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
            if (bus_stop) begin
                phase <= PH_IDLE;
            end else if (bus_start) begin
                phase <= PH_ADDR;
            end else if (byte_stb) begin
                case (phase)
                    PH_ADDR: begin
                        rsp_valid <= 1'b1;
                        if (hit) begin
                            rsp_ack <= 1'b1;
                            if (byte_in[0]) begin
                                phase  <= PH_RD;
                                rd_ptr <= '0;
                            end else begin
                                phase <= PH_SUB;
                            end
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_SUB: begin
                        rsp_valid <= 1'b1;
                        rsp_ack   <= 1'b1;
                        wr_ptr    <= byte_in;
                        phase     <= PH_WR;
                    end
                    PH_WR: begin
                        rsp_valid <= 1'b1;
                        rsp_ack   <= 1'b1;
                        wr_ptr    <= inc_sat(wr_ptr);
                    end
                    PH_RD: begin
                        rsp_valid <= 1'b1;
                        rd_ptr    <= inc_sat(rd_ptr);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sharp_ctl_regs.sv
module sharp_ctl_regs
    import sharp_ctl_pkg::*;
#(
    parameter int unsigned SET_W   = 6,
    parameter int unsigned NUM_SET = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    output ctrl_t                    ctrl_q,
    output logic [NUM_SET*SET_W-1:0] sets_q
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    logic unused_hi;
    assign unused_hi = ^wr.data[7:SET_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr.en && wr.loc == 8'd0) begin
            ctrl_q <= ctrl_t'(wr.data[CTRL_W-1:0]);
        end
    end

    for (genvar i = 0; i < NUM_SET; i++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                sets_q[i*SET_W +: SET_W] <= '0;
            end else if (wr.en && wr.loc == 8'(i + 1)) begin
                sets_q[i*SET_W +: SET_W] <= wr.data[SET_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sharp_ctl_status.sv
module sharp_ctl_status
    import sharp_ctl_pkg::*;
#(
    parameter int unsigned   ADC_W   = 6,
    parameter logic [2:0]    ID_CODE = 3'b101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             power_fail,
    input  logic             rd_fire,
    input  logic [7:0]       rd_idx,
    input  logic [ADC_W-1:0] adc_in1,
    input  logic [ADC_W-1:0] adc_in2,
    input  logic             adc_dv,
    output logic             pdd_q,
    output logic [7:0]       rsp_data
);

    logic [7:0] pick;

    always_comb begin
        case (rd_idx)
            8'd0:    pick = status_byte(pdd_q, ID_CODE, adc_dv);
            8'd1:    pick = 8'(adc_in1);
            8'd2:    pick = 8'(adc_in2);
            default: pick = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pdd_q    <= 1'b1;
            rsp_data <= '0;
        end else begin
            if (rd_fire) begin
                rsp_data <= pick;
            end
            if (power_fail) begin
                pdd_q <= 1'b1;
            end else if (rd_fire && rd_idx == 8'd0) begin
                pdd_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sharp_ctl_select.sv
module sharp_ctl_select
    import sharp_ctl_pkg::*;
#(
    parameter int unsigned SET_W   = 6,
    parameter int unsigned NUM_SET = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  ctrl_t                    reg_ctrl,
    input  logic [NUM_SET*SET_W-1:0] reg_sets,
    input  logic                     pin_ams,
    input  logic                     pin_fhs,
    input  logic                     pin_cfs,
    input  logic [NUM_SET*SET_W-1:0] pin_sets,
    output ctrl_t                    act_ctrl,
    output logic [NUM_SET*SET_W-1:0] act_sets
);

    logic use_reg;
    assign use_reg = reg_ctrl.stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ctrl <= '0;
        end else begin
            act_ctrl.stb <= reg_ctrl.stb;
            act_ctrl.ams <= use_reg ? reg_ctrl.ams : pin_ams;
            act_ctrl.fhs <= use_reg ? reg_ctrl.fhs : pin_fhs;
            act_ctrl.cfs <= use_reg ? reg_ctrl.cfs : pin_cfs;
        end
    end

    for (genvar i = 0; i < NUM_SET; i++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                act_sets[i*SET_W +: SET_W] <= '0;
            end else begin
                act_sets[i*SET_W +: SET_W] <= use_reg ? reg_sets[i*SET_W +: SET_W]
                                                      : pin_sets[i*SET_W +: SET_W];
            end
        end
    end

endmodule

// File: rtl/sharp_ctl_bank.sv
module sharp_ctl_bank
    import sharp_ctl_pkg::*;
#(
    parameter int unsigned SET_W   = 6,
    parameter logic [2:0]  ID_CODE = 3'b101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_sel,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             byte_stb,
    input  logic [7:0]       byte_in,
    output logic             rsp_valid,
    output logic             rsp_ack,
    output logic [7:0]       rsp_data,
    input  logic             power_fail,
    input  logic [SET_W-1:0] adc_in1,
    input  logic [SET_W-1:0] adc_in2,
    input  logic             adc_dv,
    input  logic             pin_ams,
    input  logic             pin_fhs,
    input  logic             pin_cfs,
    input  logic [SET_W-1:0] pin_peak,
    input  logic [SET_W-1:0] pin_steep,
    input  logic [SET_W-1:0] pin_core,
    input  logic [SET_W-1:0] pin_width,
    output logic             act_stb,
    output logic             act_ams,
    output logic             act_fhs,
    output logic             act_cfs,
    output logic [SET_W-1:0] act_peak,
    output logic [SET_W-1:0] act_steep,
    output logic [SET_W-1:0] act_core,
    output logic [SET_W-1:0] act_width
);

    localparam int unsigned NUM_SET = 4;
    localparam int unsigned FLAT_W  = NUM_SET * SET_W;

    phase_t            phase;
    wr_req_t           wr;
    logic              rd_fire;
    logic [7:0]        rd_idx;
    logic              pdd_q;
    ctrl_t             reg_ctrl;
    ctrl_t             act_ctrl;
    logic [FLAT_W-1:0] reg_sets;
    logic [FLAT_W-1:0] pin_sets;
    logic [FLAT_W-1:0] act_sets;

    assign pin_sets = {pin_width, pin_core, pin_steep, pin_peak};

    sharp_ctl_xfer u_xfer (
        .clk       (clk),
        .rst       (rst),
        .addr_sel  (addr_sel),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .byte_stb  (byte_stb),
        .byte_in   (byte_in),
        .phase     (phase),
        .wr        (wr),
        .rd_fire   (rd_fire),
        .rd_idx    (rd_idx),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack)
    );

    sharp_ctl_regs #(.SET_W(SET_W), .NUM_SET(NUM_SET)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .ctrl_q (reg_ctrl),
        .sets_q (reg_sets)
    );

    sharp_ctl_status #(.ADC_W(SET_W), .ID_CODE(ID_CODE)) u_status (
        .clk        (clk),
        .rst        (rst),
        .power_fail (power_fail),
        .rd_fire    (rd_fire),
        .rd_idx     (rd_idx),
        .adc_in1    (adc_in1),
        .adc_in2    (adc_in2),
        .adc_dv     (adc_dv),
        .pdd_q      (pdd_q),
        .rsp_data   (rsp_data)
    );

    sharp_ctl_select #(.SET_W(SET_W), .NUM_SET(NUM_SET)) u_select (
        .clk      (clk),
        .rst      (rst),
        .reg_ctrl (reg_ctrl),
        .reg_sets (reg_sets),
        .pin_ams  (pin_ams),
        .pin_fhs  (pin_fhs),
        .pin_cfs  (pin_cfs),
        .pin_sets (pin_sets),
        .act_ctrl (act_ctrl),
        .act_sets (act_sets)
    );

    assign act_stb   = act_ctrl.stb;
    assign act_ams   = act_ctrl.ams;
    assign act_fhs   = act_ctrl.fhs;
    assign act_cfs   = act_ctrl.cfs;
    assign act_peak  = act_sets[0*SET_W +: SET_W];
    assign act_steep = act_sets[1*SET_W +: SET_W];
    assign act_core  = act_sets[2*SET_W +: SET_W];
    assign act_width = act_sets[3*SET_W +: SET_W];

endmodule

// File: rtl/sharp_ctl_bank_chk.sv
module sharp_ctl_bank_chk
    import sharp_ctl_pkg::*;
#(
    parameter int unsigned SET_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_sel,
    input logic             byte_stb,
    input logic [7:0]       byte_in,
    input logic             rsp_valid,
    input logic             rsp_ack,
    input logic [7:0]       rsp_data,
    input logic             power_fail,
    input logic             pdd_q,
    input logic             rd_fire,
    input logic [7:0]       rd_idx,
    input phase_t           phase,
    input logic             act_stb,
    input logic [SET_W-1:0] pin_peak,
    input logic [SET_W-1:0] act_peak
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    addr_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_ack && $past(phase) == PH_ADDR) |-> $past(byte_in[7:1]) == dev_addr($past(addr_sel)));

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(byte_stb));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_IDLE) |-> !rsp_valid);

    // R5
    rd_noack_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(phase) == PH_RD) |-> !rsp_ack);

    // R5
    tail_ff_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_fire && rd_idx >= 8'd3) |-> rsp_data == 8'hFF);

    // R7
    pdd_set_chk: assert property (@(posedge clk) disable iff (rst)
        power_fail |=> pdd_q);

    // R7
    pdd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pdd_q) |-> $past(rd_fire && rd_idx == 8'd0));

    // R8
    pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !act_stb) |-> act_peak == $past(pin_peak));

endmodule

bind sharp_ctl_bank sharp_ctl_bank_chk #(.SET_W(SET_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .addr_sel   (addr_sel),
    .byte_stb   (byte_stb),
    .byte_in    (byte_in),
    .rsp_valid  (rsp_valid),
    .rsp_ack    (rsp_ack),
    .rsp_data   (rsp_data),
    .power_fail (power_fail),
    .pdd_q      (pdd_q),
    .rd_fire    (rd_fire),
    .rd_idx     (rd_idx),
    .phase      (phase),
    .act_stb    (act_stb),
    .pin_peak   (pin_peak),
    .act_peak   (act_peak)
);

// File: tb/sharp_ctl_bank_tb_top.sv
module sharp_ctl_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_sel = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       rsp_valid;
    logic       rsp_ack;
    logic [7:0] rsp_data;
    logic       power_fail = 1'b0;
    logic [5:0] adc_in1 = 6'h2A;
    logic [5:0] adc_in2 = 6'h15;
    logic       adc_dv = 1'b1;
    logic       pin_ams = 1'b1;
    logic       pin_fhs = 1'b0;
    logic       pin_cfs = 1'b1;
    logic [5:0] pin_peak = 6'h11;
    logic [5:0] pin_steep = 6'h22;
    logic [5:0] pin_core = 6'h33;
    logic [5:0] pin_width = 6'h0C;
    logic       act_stb, act_ams, act_fhs, act_cfs;
    logic [5:0] act_peak, act_steep, act_core, act_width;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sharp_ctl_bank dut_i (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .bus_start(bus_start),
        .bus_stop(bus_stop), .byte_stb(byte_stb), .byte_in(byte_in),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .power_fail(power_fail), .adc_in1(adc_in1), .adc_in2(adc_in2), .adc_dv(adc_dv),
        .pin_ams(pin_ams), .pin_fhs(pin_fhs), .pin_cfs(pin_cfs),
        .pin_peak(pin_peak), .pin_steep(pin_steep), .pin_core(pin_core), .pin_width(pin_width),
        .act_stb(act_stb), .act_ams(act_ams), .act_fhs(act_fhs), .act_cfs(act_cfs),
        .act_peak(act_peak), .act_steep(act_steep), .act_core(act_core), .act_width(act_width)
    );

    function automatic logic [7:0] my_addr(input logic sel, input logic rd);
        return (sel ? 8'hE0 : 8'h40) | {7'd0, rd};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic go_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, output logic v, output logic a, output logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_in = b;
        @(negedge clk); byte_stb = 1'b0;
        v = rsp_valid; a = rsp_ack; d = rsp_data;
    endtask

    task automatic wr_seq(input logic [7:0] loc, input logic [7:0] d0);
        logic v, a; logic [7:0] d;
        go_start();
        put(my_addr(addr_sel, 1'b0), v, a, d);
        put(loc, v, a, d);
        put(d0, v, a, d);
        go_stop();
    endtask

    task automatic chk_acts(input string req, input logic [3:0] c, input logic [5:0] p,
                            input logic [5:0] s, input logic [5:0] k, input logic [5:0] w);
        chk({act_cfs, act_fhs, act_ams, act_stb} == c, req, {act_cfs, act_fhs, act_ams, act_stb}, c);
        chk(act_peak == p, req, act_peak, p);
        chk(act_steep == s, req, act_steep, s);
        chk(act_core == k, req, act_core, k);
        chk(act_width == w, req, act_width, w);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic v, a;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); @(negedge clk);

        // R8: after reset standby-release is 0, pins drive the active values
        chk_acts("R8 reset pins", 4'b1010, 6'h11, 6'h22, 6'h33, 6'h0C);
        for (int x = 0; x < 64; x++) begin
            @(negedge clk);
            pin_peak = 6'(x); pin_width = 6'(63 - x);
            @(negedge clk);
            chk(act_peak == 6'(x) && act_width == 6'(63 - x), "R8 pin sweep", act_peak, x);
        end
        pin_peak = 6'h11; pin_width = 6'h0C;

        // R5 R6 R7: first read after reset
        go_start();
        put(my_addr(0, 1'b1), v, a, d);
        chk(v && a, "R1 read address ack", a, 1);
        put(8'h00, v, a, d);
        chk(d == 8'hD1, "R6 status after reset", d, 8'hD1);
        chk(v && !a, "R5 read byte not acked", a, 0);
        put(8'h00, v, a, d);
        chk(d == 8'h2A, "R5 adc1", d, 8'h2A);
        put(8'h00, v, a, d);
        chk(d == 8'h15, "R5 adc2", d, 8'h15);
        put(8'h00, v, a, d);
        chk(d == 8'hFF, "R5 pad 1", d, 8'hFF);
        put(8'h00, v, a, d);
        chk(d == 8'hFF, "R5 pad 2", d, 8'hFF);
        go_stop();

        adc_dv = 1'b0;
        go_start();
        put(my_addr(0, 1'b1), v, a, d);
        put(8'h00, v, a, d);
        chk(d == 8'h50, "R7 flag cleared by status read", d, 8'h50);
        go_stop();

        @(negedge clk); power_fail = 1'b1;
        @(negedge clk); power_fail = 1'b0;
        wr_seq(8'd7, 8'h00);
        go_start();
        put(my_addr(0, 1'b1), v, a, d);
        put(8'h00, v, a, d);
        chk(d == 8'hD0, "R7 flag survives write transfer", d, 8'hD0);
        put(8'h00, v, a, d);
        put(8'h00, v, a, d);
        go_stop();
        go_start();
        put(my_addr(0, 1'b1), v, a, d);
        put(8'h00, v, a, d);
        chk(d == 8'h50, "R7 flag clear on second read", d, 8'h50);
        go_stop();
        adc_dv = 1'b1;

        // R2 R3 R4: sequential write of the whole map and beyond
        go_start();
        put(my_addr(0, 1'b0), v, a, d);
        chk(a, "R3 write address ack", a, 1);
        put(8'h00, v, a, d);
        chk(v && a, "R3 location byte ack", a, 1);
        put(8'hF5, v, a, d);
        put(8'h05, v, a, d);
        put(8'h06, v, a, d);
        put(8'h07, v, a, d);
        put(8'h08, v, a, d);
        put(8'h3F, v, a, d);
        chk(v && a, "R4 past-end byte acked", a, 1);
        go_stop();
        @(negedge clk);
        chk_acts("R2 R3 sequential", 4'b0101, 6'h05, 6'h06, 6'h07, 6'h08);

        // R3: direct writes sweep steepness
        for (int x = 0; x < 64; x++) begin
            wr_seq(8'd2, 8'(x) | 8'hC0);
            @(negedge clk);
            chk(act_steep == 6'(x), "R3 direct steepness", act_steep, x);
        end
        wr_seq(8'd4, 8'h2E);
        @(negedge clk);
        chk(act_width == 6'h2E, "R3 direct line width", act_width, 8'h2E);

        // R4: locations above 4 change nothing
        wr_seq(8'd5, 8'h00);
        wr_seq(8'hFF, 8'h00);
        wr_seq(8'h80, 8'hFF);
        @(negedge clk);
        chk_acts("R4 past-end no effect", 4'b0101, 6'h05, 6'h3F, 6'h07, 6'h2E);

        // R9: foreign address, then stop
        go_start();
        put(8'h42, v, a, d);
        chk(v && !a, "R9 foreign address nack", a, 0);
        put(8'h01, v, a, d);
        chk(!v, "R9 silent after nack", v, 0);
        put(8'h00, v, a, d);
        chk(!v, "R9 silent after nack 2", v, 0);
        go_stop();
        @(negedge clk);
        chk(act_peak == 6'h05, "R9 no write from foreign transfer", act_peak, 8'h05);

        // R8: hand-over to pins lags by one clock
        go_start();
        put(my_addr(0, 1'b0), v, a, d);
        put(8'h00, v, a, d);
        put(8'h0E, v, a, d);
        chk(act_stb == 1'b1 && act_peak == 6'h05, "R8 old value one clock", act_peak, 8'h05);
        @(negedge clk);
        chk(act_stb == 1'b0 && act_peak == 6'h11, "R8 pins after hand-over", act_peak, 8'h11);
        go_stop();

        // R10: write then repeated start into a read
        go_start();
        put(my_addr(0, 1'b0), v, a, d);
        put(8'h01, v, a, d);
        go_start();
        put(my_addr(0, 1'b1), v, a, d);
        chk(v && a, "R10 repeated start ack", a, 1);
        put(8'h00, v, a, d);
        chk(d == 8'h51, "R10 read starts at status", d, 8'h51);
        go_stop();

        // R1: every address byte for both select levels
        for (int s = 0; s < 2; s++) begin
            @(negedge clk); addr_sel = 1'(s);
            for (int b = 0; b < 256; b++) begin
                logic exp_a;
                exp_a = (8'(b) | 8'h01) == (my_addr(1'(s), 1'b0) | 8'h01);
                go_start();
                put(8'(b), v, a, d);
                chk(v && a == exp_a, "R1 address sweep", a, exp_a);
                go_stop();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
    end

endmodule